// File: doc/BRIEF.md
# Vector Prefix Decoder and Register Number Extender

This block sits in an instruction decode stage. It looks at the 32-bit word that comes before a 32-bit instruction and decides whether that word is a vector-augmentation prefix. If it is, the block collects the 24 payload bits from their scattered positions and splits them into predicate kind, predicate selector, destination and source element widths, sub-vector length, a 9-bit per-operand extension field and a 5-bit mode field. The extension field has no fixed layout. A category code comes from a separate suffix decoder and selects how the extension field is cut into per-operand tags.

Each tag turns a 5-bit operand field, supplied by the suffix decoder, into a 7-bit register number and a vector/scalar flag. A scalar tag puts its two index bits above the field. A vector tag puts them below the field, so a vector can only start on particular alignments. The destination tag is also applied to a 3-bit condition-field operand. An illegal-instruction flag marks a reserved category or an element width that the operation class does not allow.

All decoded values are registered once, so they appear one clock after the inputs. A synchronous active-high reset clears every output.

Top module: `vpfx_top`

## Requirements
- R1: `val_o` is 1 one cycle after a prefix whose MSB0 bits 0:5 equal 000001 and whose MSB0 bits 7 and 9 are both 1. In LSB0 terms this is pfx[31:26]=1, pfx[24]=1 and pfx[22]=1. For any other prefix `val_o` is 0.
- R2: The 24-bit payload is built as MSB0 bit 6, then MSB0 bit 8, then MSB0 bits 10:31. Payload bit 0 (the first of these) is the predicate kind, bits 1:3 are the predicate selector, 4:5 are the destination width code, 6:7 are the source width code, 8:9 are the sub-vector code, 10:18 are the extension field and 19:23 are the mode. Each of these is output as it stands.
- R3: `svl_o` equals the sub-vector code plus one, so codes 00, 01, 10 and 11 give lengths 1, 2, 3 and 4.
- R4: `elw_bits_o` gives the destination width in bits: code 00 gives 0 (the instruction's default), 01 gives 32, 10 gives 16 and 11 gives 8.
- R5: A 3-bit tag with MSB 0 marks the operand scalar. The register number is {tag[1:0], field[4:0]}, so an all-zero tag leaves the field unchanged.
- R6: A 3-bit tag with MSB 1 marks the operand vector. The register number is {field[4:0], tag[1:0]}.
- R7: Category 0 uses four 2-bit tags: destination at payload bits 10:11, source 1 at 12:13, source 2 at 14:15 and source 3 at 16:17. Each tag is widened to 3 bits by appending a 0 at the LSB. Payload bit 18 is output as `xmode_o`.
- R8: Category 1 uses three 3-bit tags: destination at payload bits 10:12, source 1 at 13:15 and source 2 at 16:18. Source 3 gets a zero tag.
- R9: Category 2 uses 3-bit tags for the destination (payload bits 10:12) and source 1 (13:15). Payload bits 16:18 are output as `msrc_o`. Sources 2 and 3 get zero tags.
- R10: The condition-field number uses the destination tag and `cr_bf_i`. A scalar tag gives {00, tag[1:0], bf}. A vector tag gives {bf, tag[1], tag[0], 00}.
- R11: `ill_o` is 1 for a valid prefix when any of these holds: the category is 3; the class is 1 (double FP) and either width code is 11; the class is 2 (single FP) and either width code is 10 or 11. Class 0 is integer and class 3 is condition-field.
- R12: When the prefix does not match, every output, including `ill_o`, is zero.
- R13: While reset is asserted every output is zero, and all outputs follow their inputs with a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_i | input | 32 | Candidate prefix word |
| cat_i | input | 2 | Extension layout category from the suffix decoder |
| opc_i | input | 2 | Operation class: 0 integer, 1 double FP, 2 single FP, 3 condition-field |
| fld_dst_i | input | 5 | Destination register field |
| fld_s1_i | input | 5 | Source 1 register field |
| fld_s2_i | input | 5 | Source 2 register field |
| fld_s3_i | input | 5 | Source 3 register field |
| cr_bf_i | input | 3 | 3-bit condition-field operand |
| val_o | output | 1 | Prefix recognised |
| ill_o | output | 1 | Reserved encoding |
| mmode_o | output | 1 | Predicate kind |
| mask_o | output | 3 | Predicate selector |
| elw_o | output | 2 | Destination width code |
| elws_o | output | 2 | Source width code |
| elw_bits_o | output | 7 | Destination width in bits, 0 for default |
| svl_o | output | 3 | Sub-vector length 1..4 |
| mode_o | output | 5 | Mode field |
| xmode_o | output | 1 | Category 0 mode bit |
| msrc_o | output | 3 | Source predicate selector (category 2) |
| dst_reg_o | output | 7 | Extended destination register |
| s1_reg_o | output | 7 | Extended source 1 register |
| s2_reg_o | output | 7 | Extended source 2 register |
| s3_reg_o | output | 7 | Extended source 3 register |
| vec_o | output | 4 | Vector flags: bit 0 destination, bits 1..3 sources |
| cr_reg_o | output | 7 | Extended condition-field number |
| cr_vec_o | output | 1 | Condition-field operand is vector |

## Verification
The hardest cases to reach are prefixes that match every marker bit but one. A random word almost never lands there, yet these are exactly the cases that must decode as not valid. The stimulus builds valid prefixes from a chosen payload, then clears a single marker bit or changes the major code to produce those near misses. Illegal cases need a valid prefix together with a particular class and width pairing, so a directed set covers every width code under each class. This is followed by a long random run in which three quarters of the prefixes are built valid, with category, class and operand fields all random.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  localparam int PFX_W = 32;
  localparam int RM_W  = 24;
  localparam int XTR_W = 9;
  localparam int FLD_W = 5;
  localparam int REG_W = 7;
  localparam int CRF_W = 3;
  localparam int TAG_W = 3;
  localparam int NOPS  = 4;

  typedef enum logic [1:0] {
    CAT_S3   = 2'd0,
    CAT_S2   = 2'd1,
    CAT_TWIN = 2'd2,
    CAT_RSV  = 2'd3
  } cat_e;

  typedef enum logic [1:0] {
    OPC_INT = 2'd0,
    OPC_FPD = 2'd1,
    OPC_FPS = 2'd2,
    OPC_CR  = 2'd3
  } opc_e;

  typedef struct packed {
    logic             mmode;
    logic [2:0]       mask;
    logic [1:0]       elw;
    logic [1:0]       elws;
    logic [1:0]       svl;
    logic [XTR_W-1:0] xtr;
    logic [4:0]       mode;
  } rm_t;
endpackage

// File: rtl/vpfx_gather.sv
module vpfx_gather
  import vpfx_pkg::*;
(
  input  logic [PFX_W-1:0] pfx_i,
  output logic             hit_o,
  output rm_t              rm_o
);
  localparam logic [5:0] MAJOR = 6'd1;

  always_comb begin
    hit_o = (pfx_i[PFX_W-1 -: 6] == MAJOR) && pfx_i[24] && pfx_i[22];
    rm_o  = hit_o ? rm_t'({pfx_i[25], pfx_i[23], pfx_i[21:0]}) : '0;
  end
endmodule

// File: rtl/vpfx_extra_sel.sv
module vpfx_extra_sel
  import vpfx_pkg::*;
(
  input  cat_e                        cat_i,
  input  logic [XTR_W-1:0]            xtr_i,
  output logic [NOPS-1:0][TAG_W-1:0]  tag_o,
  output logic                        xmode_o,
  output logic [2:0]                  msrc_o
);
  always_comb begin
    tag_o   = '0;
    xmode_o = 1'b0;
    msrc_o  = '0;
    case (cat_i)
      CAT_S3: begin
        for (int i = 0; i < NOPS; i++)
          tag_o[i] = {xtr_i[XTR_W-1-2*i -: 2], 1'b0};
        xmode_o = xtr_i[0];
      end
      CAT_S2: begin
        for (int i = 0; i < 3; i++)
          tag_o[i] = xtr_i[XTR_W-1-3*i -: 3];
      end
      CAT_TWIN: begin
        for (int i = 0; i < 2; i++)
          tag_o[i] = xtr_i[XTR_W-1-3*i -: 3];
        msrc_o = xtr_i[2:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vpfx_reg_ext.sv
module vpfx_reg_ext #(
  parameter int FLD_W = 5,
  parameter int REG_W = 7
) (
  input  logic [2:0]       tag_i,
  input  logic [FLD_W-1:0] fld_i,
  output logic [REG_W-1:0] reg_o,
  output logic             vec_o
);
  localparam int EXT_W = REG_W - FLD_W;

  always_comb begin
    vec_o = tag_i[2];
    reg_o = vec_o ? {fld_i, tag_i[EXT_W-1:0]} : {tag_i[EXT_W-1:0], fld_i};
  end
endmodule

// File: rtl/vpfx_cr_ext.sv
module vpfx_cr_ext
  import vpfx_pkg::*;
(
  input  logic [2:0]       tag_i,
  input  logic [CRF_W-1:0] bf_i,
  output logic [REG_W-1:0] cr_o,
  output logic             vec_o
);
  always_comb begin
    vec_o = tag_i[2];
    cr_o  = vec_o ? {bf_i, tag_i[1], tag_i[0], 2'b00}
                  : {2'b00, tag_i[1:0], bf_i};
  end
endmodule

// File: rtl/vpfx_top.sv
module vpfx_top
  import vpfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      pfx_i,
  input  logic [1:0]       cat_i,
  input  logic [1:0]       opc_i,
  input  logic [4:0]       fld_dst_i,
  input  logic [4:0]       fld_s1_i,
  input  logic [4:0]       fld_s2_i,
  input  logic [4:0]       fld_s3_i,
  input  logic [2:0]       cr_bf_i,
  output logic             val_o,
  output logic             ill_o,
  output logic             mmode_o,
  output logic [2:0]       mask_o,
  output logic [1:0]       elw_o,
  output logic [1:0]       elws_o,
  output logic [6:0]       elw_bits_o,
  output logic [2:0]       svl_o,
  output logic [4:0]       mode_o,
  output logic             xmode_o,
  output logic [2:0]       msrc_o,
  output logic [6:0]       dst_reg_o,
  output logic [6:0]       s1_reg_o,
  output logic [6:0]       s2_reg_o,
  output logic [6:0]       s3_reg_o,
  output logic [3:0]       vec_o,
  output logic [6:0]       cr_reg_o,
  output logic             cr_vec_o
);
  logic                       hit;
  rm_t                        rm;
  cat_e                       cat;
  opc_e                       opc;
  logic [NOPS-1:0][TAG_W-1:0] tags;
  logic                       xmode_c;
  logic [2:0]                 msrc_c;
  logic [NOPS-1:0][FLD_W-1:0] flds;
  logic [NOPS-1:0][REG_W-1:0] regs_c;
  logic [NOPS-1:0]            vec_c;
  logic [REG_W-1:0]           cr_c;
  logic                       crv_c;
  logic                       ill_c;
  logic [6:0]                 bits_c;

  assign cat  = cat_e'(cat_i);
  assign opc  = opc_e'(opc_i);
  assign flds = {fld_s3_i, fld_s2_i, fld_s1_i, fld_dst_i};

  vpfx_gather u_gather (.pfx_i(pfx_i), .hit_o(hit), .rm_o(rm));

  vpfx_extra_sel u_xsel (
    .cat_i(cat), .xtr_i(rm.xtr), .tag_o(tags), .xmode_o(xmode_c), .msrc_o(msrc_c)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    vpfx_reg_ext #(.FLD_W(FLD_W), .REG_W(REG_W)) u_ext (
      .tag_i(tags[g]), .fld_i(flds[g]), .reg_o(regs_c[g]), .vec_o(vec_c[g])
    );
  end

  vpfx_cr_ext u_cr (.tag_i(tags[0]), .bf_i(cr_bf_i), .cr_o(cr_c), .vec_o(crv_c));

  always_comb begin
    case (rm.elw)
      2'b01:   bits_c = 7'd32;
      2'b10:   bits_c = 7'd16;
      2'b11:   bits_c = 7'd8;
      default: bits_c = 7'd0;
    endcase
    ill_c = hit && ((cat == CAT_RSV) ||
                    (opc == OPC_FPD && (rm.elw == 2'b11 || rm.elws == 2'b11)) ||
                    (opc == OPC_FPS && (rm.elw[1] || rm.elws[1])));
  end

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      val_o      <= 1'b0;
      ill_o      <= 1'b0;
      mmode_o    <= 1'b0;
      mask_o     <= '0;
      elw_o      <= '0;
      elws_o     <= '0;
      elw_bits_o <= '0;
      svl_o      <= '0;
      mode_o     <= '0;
      xmode_o    <= 1'b0;
      msrc_o     <= '0;
      dst_reg_o  <= '0;
      s1_reg_o   <= '0;
      s2_reg_o   <= '0;
      s3_reg_o   <= '0;
      vec_o      <= '0;
      cr_reg_o   <= '0;
      cr_vec_o   <= 1'b0;
    end else begin
      val_o      <= 1'b1;
      ill_o      <= ill_c;
      mmode_o    <= rm.mmode;
      mask_o     <= rm.mask;
      elw_o      <= rm.elw;
      elws_o     <= rm.elws;
      elw_bits_o <= bits_c;
      svl_o      <= {1'b0, rm.svl} + 3'd1;
      mode_o     <= rm.mode;
      xmode_o    <= xmode_c;
      msrc_o     <= msrc_c;
      dst_reg_o  <= regs_c[0];
      s1_reg_o   <= regs_c[1];
      s2_reg_o   <= regs_c[2];
      s3_reg_o   <= regs_c[3];
      vec_o      <= vec_c;
      cr_reg_o   <= cr_c;
      cr_vec_o   <= crv_c;
    end
  end

  // R12
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pfx_i[31:26] != 6'd1) |=> (!val_o && !ill_o && dst_reg_o == '0 && vec_o == '0 && cr_reg_o == '0));

  // R11
  ill_valid_chk: assert property (@(posedge clk) disable iff (rst) ill_o |-> val_o);

  // R3
  svl_range_chk: assert property (@(posedge clk) disable iff (rst)
    val_o |-> (svl_o >= 3'd1 && svl_o <= 3'd4));

  // R5
  scalar_low_chk: assert property (@(posedge clk) disable iff (rst)
    (val_o && !vec_o[0]) |-> (dst_reg_o[4:0] == $past(fld_dst_i)));

  // R6
  vector_high_chk: assert property (@(posedge clk) disable iff (rst)
    (val_o && vec_o[0]) |-> (dst_reg_o[6:2] == $past(fld_dst_i)));

  // R10
  cr_align_chk: assert property (@(posedge clk) disable iff (rst)
    cr_vec_o |-> (cr_reg_o[1:0] == 2'b00 && cr_reg_o[6:4] == $past(cr_bf_i)));
endmodule

// File: tb/sim_vpfx_top.sv
module sim_vpfx_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pfx_i = '0;
  logic [1:0]  cat_i = '0, opc_i = '0;
  logic [4:0]  fld_dst_i = '0, fld_s1_i = '0, fld_s2_i = '0, fld_s3_i = '0;
  logic [2:0]  cr_bf_i = '0;
  logic        val_o, ill_o, mmode_o, xmode_o, cr_vec_o;
  logic [2:0]  mask_o, svl_o, msrc_o;
  logic [1:0]  elw_o, elws_o;
  logic [6:0]  elw_bits_o, dst_reg_o, s1_reg_o, s2_reg_o, s3_reg_o, cr_reg_o;
  logic [4:0]  mode_o;
  logic [3:0]  vec_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  vpfx_top u0 (.*);

  task automatic chk(string rq, string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, nm, act, exp);
    end
  endtask

  function automatic int mkpfx(int rm);
    int p;
    p = (1 << 26) | (1 << 24) | (1 << 22);
    p |= ((rm >> 23) & 1) << 25;
    p |= ((rm >> 22) & 1) << 23;
    p |= rm & 32'h3FFFFF;
    return p;
  endfunction

  function automatic int rmf(int p, int k0, int len);
    int v;
    v = 0;
    for (int k = k0; k < k0 + len; k++) begin
      int pos;
      pos = (k == 0) ? 6 : (k == 1) ? 8 : k + 8;
      v = (v << 1) | ((p >> (31 - pos)) & 1);
    end
    return v;
  endfunction

  function automatic int xtag(int cat, int x, int op);
    if (cat == 0) return ((x >> (7 - 2*op)) & 3) * 2;
    if (cat == 1 && op < 3) return (x >> (6 - 3*op)) & 7;
    if (cat == 2 && op < 2) return (x >> (6 - 3*op)) & 7;
    return 0;
  endfunction

  function automatic int xreg(int t, int f);
    if (t >= 4) return f * 4 + (t & 3);
    return (t & 3) * 32 + f;
  endfunction

  task automatic compare();
    int p, cat, opc, x, ew, es, ok, ill, t;
    string rq, rr;
    int fl[4];
    int act[4];
    p = pfx_i; cat = cat_i; opc = opc_i;
    fl[0] = fld_dst_i; fl[1] = fld_s1_i; fl[2] = fld_s2_i; fl[3] = fld_s3_i;
    act[0] = dst_reg_o; act[1] = s1_reg_o; act[2] = s2_reg_o; act[3] = s3_reg_o;
    ok = (((p >> 26) & 63) == 1) && ((p >> 24) & 1) && ((p >> 22) & 1);
    if (!ok) begin
      rq = "R12";
      chk("R1", "val", val_o, 0);
      chk(rq, "ill", ill_o, 0);
      chk(rq, "fields", {mmode_o, mask_o, elw_o, elws_o, mode_o, xmode_o, msrc_o, svl_o}, 0);
      chk(rq, "regs", {dst_reg_o, s1_reg_o, s2_reg_o, s3_reg_o}, 0);
      chk(rq, "vec", {vec_o, cr_vec_o, cr_reg_o, elw_bits_o}, 0);
      return;
    end
    x  = rmf(p, 10, 9);
    ew = rmf(p, 4, 2);
    es = rmf(p, 6, 2);
    chk("R1", "val", val_o, 1);
    chk("R2", "mmode", mmode_o, rmf(p, 0, 1));
    chk("R2", "mask", mask_o, rmf(p, 1, 3));
    chk("R2", "elw", elw_o, ew);
    chk("R2", "elws", elws_o, es);
    chk("R2", "mode", mode_o, rmf(p, 19, 5));
    chk("R3", "svl", svl_o, rmf(p, 8, 2) + 1);
    chk("R4", "elw_bits", elw_bits_o, ew == 0 ? 0 : ew == 1 ? 32 : ew == 2 ? 16 : 8);
    ill = (cat == 3) || (opc == 1 && (ew == 3 || es == 3)) || (opc == 2 && (ew >= 2 || es >= 2));
    chk("R11", "ill", ill_o, ill);
    chk("R7", "xmode", xmode_o, cat == 0 ? (x & 1) : 0);
    chk("R9", "msrc", msrc_o, cat == 2 ? (x & 7) : 0);
    rr = cat == 0 ? "R7" : cat == 1 ? "R8" : cat == 2 ? "R9" : "R11";
    for (int i = 0; i < 4; i++) begin
      t = xtag(cat, x, i);
      rq = (t >= 4) ? "R6" : "R5";
      chk(rq, {rr, " reg"}, act[i], xreg(t, fl[i]));
      chk(rq, {rr, " vec"}, vec_o[i], t >= 4);
    end
    t = xtag(cat, x, 0);
    chk("R10", "cr", cr_reg_o,
        t >= 4 ? cr_bf_i * 16 + ((t >> 1) & 1) * 8 + (t & 1) * 4 : (t & 3) * 8 + cr_bf_i);
    chk("R10", "crvec", cr_vec_o, t >= 4);
  endtask

  task automatic run(int p, int c, int o, int f0, int f1, int f2, int f3, int bf);
    pfx_i = p; cat_i = c[1:0]; opc_i = o[1:0];
    fld_dst_i = f0[4:0]; fld_s1_i = f1[4:0]; fld_s2_i = f2[4:0]; fld_s3_i = f3[4:0];
    cr_bf_i = bf[2:0];
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: outputs held at zero under reset even with a valid prefix applied
    pfx_i = mkpfx(24'hFFFFFF);
    @(negedge clk);
    chk("R13", "rst val", val_o, 0);
    chk("R13", "rst regs", {dst_reg_o, cr_reg_o, svl_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R13", "latency", val_o, 1);
    // identity: zero payload keeps fields (R5)
    run(mkpfx(0), 0, 0, 7, 13, 21, 31, 5);
    run(mkpfx(0), 1, 0, 31, 1, 2, 3, 7);
    // category 0 vectors and mode bit (R7)
    run(mkpfx(9'b10_11_01_10_1 << 5), 0, 0, 3, 9, 17, 30, 2);
    // category 1 mixed tags (R8)
    run(mkpfx(9'b111_100_011 << 5), 1, 0, 31, 5, 31, 4, 6);
    // category 2 twin with source mask (R9)
    run(mkpfx(9'b101_010_110 << 5), 2, 3, 11, 22, 1, 1, 3);
    // widths and sub-vector (R3, R4, R11)
    for (int e = 0; e < 16; e++)
      for (int o = 0; o < 4; o++)
        run(mkpfx((e << 16) | ((e & 3) << 14) | 24'h800000), o, o, e, e, e, e, e);
    // reserved category (R11)
    run(mkpfx(24'h00FFE0), 3, 0, 1, 2, 3, 4, 1);
    // near misses (R1, R12)
    run(mkpfx(24'h123456) & ~(1 << 24), 0, 0, 5, 5, 5, 5, 5);
    run(mkpfx(24'h123456) & ~(1 << 22), 1, 2, 5, 5, 5, 5, 5);
    run(mkpfx(24'h123456) | (1 << 27), 2, 1, 5, 5, 5, 5, 5);
    run(32'hFFFFFFFF, 0, 0, 5, 5, 5, 5, 5);
    for (int n = 0; n < 3000; n++) begin
      int p;
      p = ($urandom % 4 != 0) ? mkpfx($urandom & 24'hFFFFFF) : $urandom;
      run(p, $urandom % 4, $urandom % 4, $urandom % 32, $urandom % 32,
          $urandom % 32, $urandom % 32, $urandom % 8);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule